// File: doc/BRIEF.md
# Inter-Processor Doorbell Register Bank

This block holds a set of doorbell register pairs, one pair for each processor core that can receive an interrupt. Any bus master writes a pair's raise register to signal the core and writes its drop register to withdraw the signal. Each pair stores one shared word: an interrupt flag in bit 0 and a 28-bit source-identifier field in bits 31 down to 4. Software decides what each source bit means. Both registers of a pair read back that same word. A 1 written to the raise register sets bits. A 1 written to the drop register clears bits. A 0 leaves a bit as it was.

The slot index space is sparse. A parameter mask chooses which indices have storage, so one module serves both a large bank and a small bank. Raise registers sit at `SET_BASE + 4*index` and drop registers at `CLR_BASE + 4*index`. Every populated slot drives one level interrupt line. That line follows the stored flag. The register-space lock input goes to the block, but the doorbells do not use it, so no unlock sequence is needed before writing them.

Top module: `ipc_doorbell`

## Requirements
- R1: A write with bit 0 = 1 to the raise register of a populated slot sets that slot's flag. Its `irq_out` bit is 1 from the clock edge that accepts the write.
- R2: A write with bit 0 = 1 to the drop register of a populated slot clears the flag. Its `irq_out` bit is 0 from the accepting edge.
- R3: A 1 in any of bits 31..4 written to the raise register sets that source bit. The bit then reads as 1 through both the raise and the drop address of the slot.
- R4: A 1 in any of bits 31..4 written to the drop register clears that source bit. The bit then reads as 0 through both addresses. Bits written as 0 through either register keep their value.
- R5: Bits 3..1 of every register are reserved. Writes to them are ignored, and they always read as 0.
- R6: The `lock_en` input has no effect. Writes are accepted whether it is 0 or 1.
- R7: An access to an unpopulated index, to an index at or past `NUM_SLOTS`, or to an address with bits 1..0 not 00 writes nothing and reads 0. Interrupt lines of unpopulated slots are always 0.
- R8: Synchronous active-high reset clears all stored state, all `irq_out` bits and `bus_ready`.
- R9: `bus_ready` is 1 exactly in the cycle after a cycle with `bus_req` = 1. For a read request, `bus_rdata` carries the addressed word in that cycle.
- R10: `irq_out` changes only on an accepted write, and each slot's line moves independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| bus_ready | output | 1 | Access completed, one cycle after request |
| lock_en | input | 1 | Register-space lock state (not used by this block) |
| irq_out | output | NUM_SLOTS | Level interrupt, one line per slot index |

## Verification
The bench builds the block with its default sizing: 20 slot indices with the sparse population 0, 1, 8, 9, 16–19, a raise base of 0x000 and a drop base of 0x100. With this sizing, an index sweep covers every populated slot, every gap in the population and the first index past the end. For each index it raises and drops each of the 32 data bits one at a time, reads back through both addresses and compares all interrupt lines. Further checks cover masked clears, writes of zero and misaligned addresses.

// File: rtl/ipc_doorbell.sv
module ipc_doorbell #(
  parameter int NUM_SLOTS = 20,
  parameter logic [NUM_SLOTS-1:0] POP_MASK = 'h0F0303,
  parameter int ADDR_W = 12,
  parameter int SET_BASE = 'h000,
  parameter int CLR_BASE = 'h100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  input  logic                 lock_en,
  output logic [NUM_SLOTS-1:0] irq_out
);

  localparam logic [31:0] LIVE_BITS = 32'hFFFF_FFF1;

  logic [NUM_SLOTS-1:0]       set_hit, clr_hit;
  logic [NUM_SLOTS-1:0][31:0] slot_q;
  logic [31:0]                rd_word;
  logic [31:0]                wmask;
  logic                       unused_lock;

  assign unused_lock = lock_en;
  assign wmask       = bus_wdata & LIVE_BITS;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign set_hit[i] = bus_req && (bus_addr == ADDR_W'(SET_BASE + 4 * i));
    assign clr_hit[i] = bus_req && (bus_addr == ADDR_W'(CLR_BASE + 4 * i));

    if (POP_MASK[i]) begin : g_on
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (bus_we && set_hit[i])
          q <= q | wmask;
        else if (bus_we && clr_hit[i])
          q <= q & ~wmask;
      end
      assign slot_q[i] = q;
    end else begin : g_off
      assign slot_q[i] = '0;
    end

    assign irq_out[i] = slot_q[i][0];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (set_hit[i] || clr_hit[i])
        rd_word = slot_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_word : '0;
    end
  end

endmodule

module ipc_doorbell_chk #(
  parameter int NUM_SLOTS = 20,
  parameter logic [NUM_SLOTS-1:0] POP_MASK = 'h0F0303,
  parameter int ADDR_W = 12,
  parameter int SET_BASE = 'h000,
  parameter int CLR_BASE = 'h100
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_ready,
  input logic [NUM_SLOTS-1:0] irq_out
);

  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0 && !bus_ready));

  a_r9_ready_after_req: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);

  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> bus_rdata[3:1] == 3'b000);

  a_r7_unpop_silent: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~POP_MASK) == '0);

  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(irq_out));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_k
    if (POP_MASK[k]) begin : g_p
      a_r1_set_raises: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(SET_BASE + 4 * k) && bus_wdata[0])
        |=> irq_out[k]);
      a_r2_clr_drops: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(CLR_BASE + 4 * k) && bus_wdata[0])
        |=> !irq_out[k]);
    end
  end

endmodule

bind ipc_doorbell ipc_doorbell_chk #(
  .NUM_SLOTS(NUM_SLOTS), .POP_MASK(POP_MASK), .ADDR_W(ADDR_W),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_ready(bus_ready), .irq_out(irq_out)
);

// File: tb/ipc_doorbell_bench.sv
module ipc_doorbell_bench;
  localparam int N = 20;
  localparam logic [N-1:0] POP = 'h0F0303;
  localparam int AW = 12;
  localparam int SB = 'h000;
  localparam int CB = 'h100;
  localparam logic [31:0] LIVE = 32'hFFFF_FFF1;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0, lock_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready;
  logic [N-1:0] irq_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [N];

  always #5 clk = ~clk;

  ipc_doorbell #(.NUM_SLOTS(N), .POP_MASK(POP), .ADDR_W(AW), .SET_BASE(SB), .CLR_BASE(CB))
    u_ipc_doorbell (.clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .lock_en(lock_en), .irq_out(irq_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model[i][0];
    return v;
  endfunction

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_req = 0;
    check("R9 ready", 32'(bus_ready), 32'd1);
    d = bus_rdata;
  endtask

  task automatic mset(int i, logic [31:0] d);
    if (i < N && POP[i]) model[i] |= d & LIVE;
  endtask
  task automatic mclr(int i, logic [31:0] d);
    if (i < N && POP[i]) model[i] &= ~(d & LIVE);
  endtask
  function automatic logic [31:0] mget(int i);
    return (i < N) ? model[i] : 32'h0;
  endfunction

  task automatic read_both(int i, string tag);
    logic [31:0] v;
    rd(SB + 4 * i, v); check(tag, v, mget(i));
    rd(CB + 4 * i, v); check(tag, v, mget(i));
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R8 irq after reset", 32'(irq_out), 32'h0);
    check("R8 ready after reset", 32'(bus_ready), 32'h0);
    rst = 0;
    @(negedge clk);
    check("R9 ready idle", 32'(bus_ready), 32'h0);
    for (int i = 0; i < N; i++) read_both(i, "R8 state zero");

    for (int i = 0; i <= N; i++) begin
      for (int b = 0; b < 32; b++) begin
        lock_en = b[0];
        wr(SB + 4 * i, 32'h1 << b); mset(i, 32'h1 << b);
        check("R1/R6/R7 irq after set", 32'(irq_out), 32'(exp_irq()));
        read_both(i, "R3/R5/R7 read after set");
        lock_en = ~b[0];
        wr(CB + 4 * i, 32'h1 << b); mclr(i, 32'h1 << b);
        check("R2/R10 irq after clr", 32'(irq_out), 32'(exp_irq()));
        read_both(i, "R4/R5 read after clr");
      end
    end

    for (int i = 0; i < N; i++) begin
      wr(SB + 4 * i, 32'hFFFF_FFFF); mset(i, 32'hFFFF_FFFF);
      wr(CB + 4 * i, 32'hA5A5_A5A4); mclr(i, 32'hA5A5_A5A4);
      wr(SB + 4 * i, 32'h0); wr(CB + 4 * i, 32'h0);
      read_both(i, "R4 masked clear and zero writes");
    end
    check("R10 per-slot lines", 32'(irq_out), 32'(exp_irq()));

    wr(CB + 4 * 8, 32'h1); mclr(8, 32'h1);
    check("R10 single line drop", 32'(irq_out), 32'(exp_irq()));

    wr(SB + 4 * 9 + 1, 32'hFFFF_FFFF);
    wr(CB + 4 * 1 + 2, 32'hFFFF_FFFF);
    wr(CB + 4 * N, 32'hFFFF_FFFF);
    rd(SB + 4 * 9 + 1, v); check("R7 misaligned read", v, 32'h0);
    read_both(9, "R7 misaligned write ignored");
    read_both(1, "R7 misaligned clr ignored");
    check("R7 irq unchanged", 32'(irq_out), 32'(exp_irq()));

    rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < N; i++) model[i] = '0;
    check("R8 irq after second reset", 32'(irq_out), 32'h0);
    read_both(16, "R8 state after second reset");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule